// File: doc/BRIEF.md
# Serial-Configured Clock Output Enable Controller

This block gates a bank of seven copies of an incoming clock. A two-wire serial slave sets which copies run. The slave only receives. A transfer opens with a start condition, then an address byte that must select this device for writing. Two header bytes follow: a command code and a byte count. Their values do not matter, but both are acknowledged. After them, the data bytes are stored in order into two enable bytes. There is no sub-address, so reaching the second enable byte means sending the first one as well.

The serial lines are sampled with a fast system clock. That clock must run at least eight times faster than SCL. SCL and SDA each pass through a two-flop synchronizer, and start, stop and bit edges are found from the synchronized values. The slave drives SDA open-drain through a pull-low enable.

Each output clock is the buffered input clock ANDed with a per-output gate. A gate takes a new enable value only while the input clock is low. As a result, switching an output on or off never cuts a pulse short.

Top module: `clkbuf_en_ctrl`

## Requirements
- R1: After reset all seven enables are set, so every output follows the input clock.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A stop ends the transfer and releases SDA.
- R3: The address byte 0xD2 (address 1101001, R/W bit 0) is acknowledged by pulling SDA low for the ninth SCL pulse. The pull-low begins only while SCL is low.
- R4: Any other address byte, including the read form 0xD3, gets no acknowledge. Every byte after it is also ignored and unacknowledged until the next start.
- R5: After a matched address, the next two bytes (command code and byte count) are acknowledged and have no effect on any enable.
- R6: The fourth byte of a transfer loads enable byte 0 and the fifth loads enable byte 1. A transfer that stops after the fourth byte leaves enable byte 1 unchanged.
- R7: Enable byte 0 bit 2 gates output 0, bit 3 gates output 1 and bit 7 gates output 2. Its other bits are unused.
- R8: Enable byte 1 bit 2 gates output 3, bit 3 gates output 4, bit 6 gates output 5 and bit 7 gates output 6. Its other bits are unused.
- R9: An output whose enable is 0 stays low. An output whose enable is 1 equals the input clock.
- R10: A gate changes only while the input clock is low, so no output ever shows a shortened pulse.
- R11: Bytes after the fifth are acknowledged and ignored.
- R12: A repeated start in the middle of a transfer restarts byte counting at the address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | When 1, pull SDA low (acknowledge) |
| buf_clk | input | 1 | Clock to be buffered |
| clk_out | output | 7 | Gated copies of buf_clk |

## Verification
The bench walks a single set bit through both enable bytes and also writes all-zero and all-one patterns. A wrong bit-to-output mapping would then light the wrong output, or leave an unused bit driving a gate. It sends a wrong address and the read form of the correct one. A slave that acknowledged these, or that kept storing the bytes after them, would show stray ACKs or changed outputs. It stops a transfer after the first data byte, to catch a design that clears or shifts the second byte. It adds trailing extra bytes, to catch one that wraps them back onto the enable bytes. It also sends a repeated start mid-header, which a byte counter that is not reset would turn into a misplaced write. A monitor across the whole run flags any output edge that does not line up with an edge of the input clock, which is the mark of gating that switches mid-pulse.

// File: rtl/clkbuf_en_pkg.sv
package clkbuf_en_pkg;
  localparam int NUM_OUT   = 7;
  localparam int NUM_DATA  = 2;
  localparam int HDR_BYTES = 3;
  localparam int SEL_W     = (NUM_DATA > 1) ? $clog2(NUM_DATA) : 1;
  localparam logic [7:0] DEV_BYTE = 8'hD2;
  // which enable byte feeds each output (bit i = output i)
  localparam logic [NUM_OUT-1:0][SEL_W-1:0] OUT_SEL = 7'b1111000;
  // bit position inside that byte, output 6 first
  localparam logic [NUM_OUT-1:0][2:0] OUT_POS =
    {3'd7, 3'd6, 3'd3, 3'd2, 3'd7, 3'd3, 3'd2};
endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] raw, cur, old;
  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES-1:0] pipe;
    logic              prev;
    always_ff @(posedge clk) begin
      if (rst) begin
        pipe <= '1;
        prev <= 1'b1;
      end else begin
        pipe <= {pipe[STAGES-2:0], raw[g]};
        prev <= pipe[STAGES-1];
      end
    end
    assign cur[g] = pipe[STAGES-1];
    assign old[g] = prev;
  end

  assign scl_s     = cur[0];
  assign sda_s     = cur[1];
  assign scl_rise  = cur[0] & ~old[0];
  assign scl_fall  = ~cur[0] & old[0];
  assign start_det = cur[0] & old[0] & old[1] & ~cur[1];
  assign stop_det  = cur[0] & old[0] & ~old[1] & cur[1];
endmodule

// File: rtl/wr_slave.sv
module wr_slave
  import clkbuf_en_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [SEL_W-1:0] wr_sel,
  output logic [7:0]       wr_data
);
  localparam int IDX_MAX = HDR_BYTES + NUM_DATA;
  localparam int IDX_W   = $clog2(IDX_MAX + 1);
  localparam logic [IDX_W-1:0] HDR_I = IDX_W'(HDR_BYTES);
  localparam logic [IDX_W-1:0] MAX_I = IDX_W'(IDX_MAX);

  typedef enum logic [1:0] {ST_IDLE, ST_RX, ST_ACK} st_t;
  st_t              state;
  logic [3:0]       bit_cnt;
  logic [7:0]       shreg;
  logic [IDX_W-1:0] byte_idx;
  logic             matched;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      byte_idx <= '0;
      matched  <= 1'b0;
      sda_oe   <= 1'b0;
      wr_en    <= 1'b0;
      wr_sel   <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state    <= ST_RX;
        bit_cnt  <= '0;
        byte_idx <= '0;
        matched  <= 1'b0;
        sda_oe   <= 1'b0;
      end else if (stop_det) begin
        state   <= ST_IDLE;
        matched <= 1'b0;
        sda_oe  <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise && bit_cnt < 4'd8) begin
              shreg   <= {shreg[6:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              if (byte_idx == '0) begin
                if (shreg == DEV_BYTE) begin
                  matched <= 1'b1;
                  sda_oe  <= 1'b1;
                  state   <= ST_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                sda_oe <= 1'b1;
                state  <= ST_ACK;
                if (byte_idx >= HDR_I && byte_idx < MAX_I) begin
                  wr_en   <= 1'b1;
                  wr_sel  <= SEL_W'(byte_idx - HDR_I);
                  wr_data <= shreg;
                end
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              sda_oe  <= 1'b0;
              bit_cnt <= '0;
              state   <= ST_RX;
              if (byte_idx != MAX_I) byte_idx <= byte_idx + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R3
  ack_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s);
  // R2
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);
  // R4
  wr_needs_match_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> matched);
endmodule

// File: rtl/en_bank.sv
module en_bank
  import clkbuf_en_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [7:0]         wr_data,
  output logic [NUM_OUT-1:0] en_q
);
  logic unused_data;
  assign unused_data = ^wr_data;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        en_q[i] <= 1'b1;
      else if (wr_en && wr_sel == OUT_SEL[i])
        en_q[i] <= wr_data[OUT_POS[i]];
    end
  end

  // R1
  en_reset_chk: assert property (@(posedge clk)
    rst |=> en_q == '1);
  // R5
  en_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(en_q));
endmodule

// File: rtl/out_gate.sv
module out_gate #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         buf_clk,
  input  logic [N-1:0] en,
  output logic [N-1:0] clk_out
);
  logic [N-1:0] gate_q;

  always_ff @(posedge clk) begin
    if (rst)
      gate_q <= '1;
    else if (!buf_clk)
      gate_q <= en;
  end

  assign clk_out = {N{buf_clk}} & gate_q;

  // R10
  gate_low_chk: assert property (@(posedge clk) disable iff (rst)
    (gate_q != $past(gate_q)) |-> !$past(buf_clk));
endmodule

// File: rtl/clkbuf_en_ctrl.sv
module clkbuf_en_ctrl
  import clkbuf_en_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic               buf_clk,
  output logic [NUM_OUT-1:0] clk_out
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [SEL_W-1:0] wr_sel;
  logic [7:0] wr_data;
  logic [NUM_OUT-1:0] en_q;

  line_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  wr_slave u_slave (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data));

  en_bank u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .en_q(en_q));

  out_gate #(.N(NUM_OUT)) u_gate (
    .clk(clk), .rst(rst), .buf_clk(buf_clk), .en(en_q), .clk_out(clk_out));
endmodule

// File: tb/clkbuf_en_ctrl_test.sv
`timescale 1ns/1ps
module clkbuf_en_ctrl_test;
  localparam int Q = 10;
  logic clk = 1'b0, rst = 1'b1, scl = 1'b1, sda_m = 1'b1, bufclk = 1'b0;
  logic sda_oe;
  logic [6:0] clk_out;
  wire sda_bus = sda_m & ~sda_oe;
  int checks = 0, fails = 0, runts = 0, cyc = 0, bc = 0;
  logic done = 1'b0;
  logic [6:0] exp_en = 7'h7F;
  logic [6:0] prev_out = '0;
  logic prev_buf = 1'b0;

  clkbuf_en_ctrl uut (.clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .buf_clk(bufclk), .clk_out(clk_out));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    bc <= (bc == 2) ? 0 : bc + 1;
    if (bc == 2) bufclk <= ~bufclk;
  end

  // R10 monitor: an output edge must coincide with an input clock edge
  always @(negedge clk) begin
    if (!rst)
      for (int i = 0; i < 7; i++)
        if (clk_out[i] != prev_out[i] && bufclk == prev_buf) runts++;
    prev_out = clk_out;
    prev_buf = bufclk;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic logic [6:0] map_en(input logic [7:0] b0, input logic [7:0] b1);
    return {b1[7], b1[6], b1[3], b1[2], b0[7], b0[3], b0[2]};
  endfunction

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b1; wq(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int k = 7; k >= 0; k--) begin
      sda_m = b[k]; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
    end
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q);
    ack = sda_oe;
    wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic xfer(input logic [7:0] bytes [8], input int n, output logic [7:0] acks);
    logic a;
    acks = '0;
    bus_start();
    for (int k = 0; k < n; k++) begin
      send_byte(bytes[k], a);
      acks[k] = a;
    end
    bus_stop();
  endtask

  task automatic chk_acks(input logic [7:0] got, input logic [7:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s acks actual=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic chk_outs(input string tag);
    int bad = 0;
    wq(20);
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (clk_out !== ({7{bufclk}} & exp_en)) bad++;
    end
    checks++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s outputs actual=%b expected=%b (mismatch cycles=%0d)",
               tag, clk_out, {7{bufclk}} & exp_en, bad);
    end
  endtask

  initial begin
    logic [7:0] bytes [8];
    logic [7:0] acks;
    logic [7:0] b0, b1;
    logic a;
    wq(5); rst = 1'b0; wq(5);
    chk_outs("R1 reset all enabled");

    // sweep: walking one in each byte, plus zeros and ones
    for (int p = 0; p < 10; p++) begin
      b0 = (p < 8) ? 8'(1 << p) : ((p == 8) ? 8'h00 : 8'hFF);
      b1 = (p < 8) ? 8'(1 << (7 - p)) : ((p == 8) ? 8'h00 : 8'hFF);
      bytes[0] = 8'hD2; bytes[1] = 8'(p * 37); bytes[2] = 8'(~p);
      bytes[3] = b0; bytes[4] = b1;
      xfer(bytes, 5, acks);
      chk_acks(acks, 8'h1F, "R3 R5 full write");
      exp_en = map_en(b0, b1);
      chk_outs("R6 R7 R8 R9 mapping");
    end

    // R6 partial transfer: only byte 0
    bytes[0] = 8'hD2; bytes[1] = 8'hAA; bytes[2] = 8'h02; bytes[3] = 8'h84;
    xfer(bytes, 4, acks);
    chk_acks(acks, 8'h0F, "R6 partial");
    exp_en = {exp_en[6:3], 1'b1, 1'b0, 1'b1};
    chk_outs("R6 partial keeps byte1");

    // R4 wrong address
    bytes[0] = 8'hD4; bytes[1] = 8'h00; bytes[2] = 8'h00; bytes[3] = 8'h00; bytes[4] = 8'h00;
    xfer(bytes, 5, acks);
    chk_acks(acks, 8'h00, "R4 wrong address");
    chk_outs("R4 wrong address no change");

    // R4 read form
    bytes[0] = 8'hD3;
    xfer(bytes, 5, acks);
    chk_acks(acks, 8'h00, "R4 read rejected");
    chk_outs("R4 read no change");

    // R12 repeated start after command byte
    bus_start();
    send_byte(8'hD2, a); acks[0] = a;
    send_byte(8'hFF, a); acks[1] = a;
    bytes[0] = 8'hD2; bytes[1] = 8'h11; bytes[2] = 8'h22; bytes[3] = 8'h88; bytes[4] = 8'h48;
    xfer(bytes, 5, acks);
    chk_acks(acks, 8'h1F, "R12 repeated start");
    exp_en = map_en(8'h88, 8'h48);
    chk_outs("R12 restart positions");

    // R11 extra bytes acked and ignored
    bytes[0] = 8'hD2; bytes[1] = 8'h00; bytes[2] = 8'h00; bytes[3] = 8'h0C; bytes[4] = 8'hC0;
    bytes[5] = 8'h00; bytes[6] = 8'h00;
    xfer(bytes, 7, acks);
    chk_acks(acks, 8'h7F, "R11 extra bytes");
    exp_en = map_en(8'h0C, 8'hC0);
    chk_outs("R11 extras ignored");

    // R2 stop releases SDA
    checks++;
    if (sda_oe !== 1'b0) begin
      fails++;
      $display("FAIL R2 sda after stop actual=%b expected=0", sda_oe);
    end

    checks++;
    if (runts != 0) begin
      fails++;
      $display("FAIL R10 runt edges actual=%0d expected=0", runts);
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule